// File: doc/BRIEF.md
# Synchronizable Up-Down PWM Timebase

This block is the time base of a PWM channel. A counter runs against an active period value in one of three styles: rising sawtooth, falling sawtooth, or a symmetric triangle that climbs from zero to the period and falls back. Two single-cycle strobes mark the moments the counter sits at zero and at the period. Comparators and output logic sit downstream and use these strobes and the counter value.

Several channels can be kept in lockstep. A sync event, from the `sync_in` pin or from the software strobe `sw_sync`, can reload the counter with a phase offset and set the direction it continues in. Each channel emits `sync_out`, chosen from the incoming sync, its own zero strobe or its own period strobe, so channels can be chained. The period is written through a shadow register. That register is copied to the active period at the zero point, or it can be written straight through when `prd_direct` is set.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the counter is 0, `dir_up` is 1 and the active period is 0. While `tick_en` is low, no strobe is asserted.
- R2: With `cnt_mode` = 00 (up), every enabled tick adds one to the counter and sets `dir_up`. When the counter is at or above the active period, the next value is 0, so one cycle spans period+1 ticks.
- R3: With `cnt_mode` = 01 (down), every enabled tick takes one from the counter and clears `dir_up`. When the counter is 0, the next value is the active period.
- R4: With `cnt_mode` = 10 (up-down), the counter moves by one per tick. Counting up, at or above the period, it turns down (`dir_up` goes to 0). Counting down, at 0, it turns up (`dir_up` goes to 1). One full cycle is twice the period in ticks.
- R5: With `cnt_mode` = 11, the counter and direction are frozen and no strobe is asserted.
- R6: While `tick_en` is low, the counter holds its value.
- R7: When `phase_en` is 1 and a sync event occurs, the counter takes `phase_val` on the next clock, whatever `tick_en` is. `dir_up` takes `phase_up`: 1 means count up afterwards, 0 means count down. This load wins over a wrap or turn due in the same cycle.
- R8: When `phase_en` is 0, a sync event leaves the counter and direction untouched.
- R9: A pulse on `sw_sync` acts exactly like a pulse on `sync_in`.
- R10: `zero_evt` and `prd_evt` are combinational. Each is high in a clock where `tick_en` is 1, the mode is not 11, and the counter equals 0 or the active period respectively.
- R11: `sync_out` follows `sync_sel`: 00 gives the sync event (`sync_in` or `sw_sync`), 01 gives `zero_evt`, 10 gives `prd_evt`, 11 keeps it at 0.
- R12: With `prd_direct` = 1, a write (`prd_wr`) is active from the next clock. With `prd_direct` = 0, a write lands in the shadow register, which is copied to the active period on a clock where `zero_evt` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick_en | input | 1 | Count enable for this clock |
| cnt_mode | input | 2 | 00 up, 01 down, 10 up-down, 11 frozen |
| sync_in | input | 1 | External sync pulse |
| sw_sync | input | 1 | Software sync pulse |
| phase_en | input | 1 | Allow sync events to load the phase |
| phase_up | input | 1 | Direction after a phase load (1 = up) |
| phase_val | input | W | Phase value loaded on sync |
| sync_sel | input | 2 | Source select for sync_out |
| prd_direct | input | 1 | 1 = write active period directly, 0 = via shadow |
| prd_wr | input | 1 | Period write strobe |
| prd_wdata | input | W | Period write data |
| count | output | W | Counter value |
| dir_up | output | 1 | Current counting direction (1 = up) |
| zero_evt | output | 1 | Counter-equals-zero strobe |
| prd_evt | output | 1 | Counter-equals-period strobe |
| sync_out | output | 1 | Chained sync pulse |

## Verification
The bench builds the block with W = 8 and uses active periods of 4, 6 and 3. These small periods let a single run cover several full sawtooth and triangle cycles, every turn point, and a shadow transfer. They also make it practical to place a phase load exactly on the cycle of a period wrap. An 8-bit width leaves the counter far from overflow, so every expected value follows directly from the period and mode arithmetic.

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic [1:0]   cnt_mode,
  input  logic         sync_in,
  input  logic         sw_sync,
  input  logic         phase_en,
  input  logic         phase_up,
  input  logic [W-1:0] phase_val,
  input  logic [1:0]   sync_sel,
  input  logic         prd_direct,
  input  logic         prd_wr,
  input  logic [W-1:0] prd_wdata,
  output logic [W-1:0] count,
  output logic         dir_up,
  output logic         zero_evt,
  output logic         prd_evt,
  output logic         sync_out
);
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] prd_act, prd_shd, nxt_cnt;
  logic         nxt_dir;

  wire sync_evt = sync_in | sw_sync;
  wire load     = phase_en & sync_evt;
  wire run      = tick_en & (cnt_mode != 2'b11);

  assign zero_evt = run & (count == ZERO);
  assign prd_evt  = run & (count == prd_act);

  always_comb begin
    case (sync_sel)
      2'b00:   sync_out = sync_evt;
      2'b01:   sync_out = zero_evt;
      2'b10:   sync_out = prd_evt;
      default: sync_out = 1'b0;
    endcase
  end

  always_comb begin
    nxt_cnt = count;
    nxt_dir = dir_up;
    if (load) begin
      nxt_cnt = phase_val;
      nxt_dir = phase_up;
    end else if (run) begin
      case (cnt_mode)
        2'b00: begin
          nxt_dir = 1'b1;
          nxt_cnt = (count >= prd_act) ? ZERO : count + ONE;
        end
        2'b01: begin
          nxt_dir = 1'b0;
          nxt_cnt = (count == ZERO) ? prd_act : count - ONE;
        end
        default: begin
          if (prd_act == ZERO) begin
            nxt_cnt = ZERO;
          end else if (dir_up) begin
            if (count >= prd_act) begin
              nxt_dir = 1'b0;
              nxt_cnt = count - ONE;
            end else begin
              nxt_cnt = count + ONE;
            end
          end else begin
            if (count == ZERO) begin
              nxt_dir = 1'b1;
              nxt_cnt = ONE;
            end else begin
              nxt_cnt = count - ONE;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= ZERO;
      dir_up  <= 1'b1;
      prd_act <= ZERO;
      prd_shd <= ZERO;
    end else begin
      count  <= nxt_cnt;
      dir_up <= nxt_dir;
      if (prd_wr) prd_shd <= prd_wdata;
      if (prd_wr && prd_direct)         prd_act <= prd_wdata;
      else if (!prd_direct && zero_evt) prd_act <= prd_shd;
    end
  end

  AST_PHASE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(phase_val)) && (dir_up == $past(phase_up))); // R7

  AST_SYNC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase_en && !tick_en) |=> (count == $past(count)) && (dir_up == $past(dir_up))); // R8

  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_mode == 2'b11 && !load) |=> $stable(count)); // R5

  AST_TURN_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && cnt_mode == 2'b10 && dir_up && prd_act != ZERO && count >= prd_act)
    |=> !dir_up); // R4

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!prd_direct && !zero_evt) |=> $stable(prd_act)); // R12

  AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && cnt_mode == 2'b00 && prd_evt) |=> count == ZERO); // R2
endmodule

// File: tb/test_pwm_timebase.sv
module test_pwm_timebase;
  localparam int W = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst_n = 1'b0, tick_en = 1'b0, sync_in = 1'b0, sw_sync = 1'b0;
  logic         phase_en = 1'b0, phase_up = 1'b0, prd_direct = 1'b1, prd_wr = 1'b0;
  logic [1:0]   cnt_mode = 2'b00, sync_sel = 2'b11;
  logic [W-1:0] phase_val = '0, prd_wdata = '0;
  logic [W-1:0] count;
  logic         dir_up, zero_evt, prd_evt, sync_out;

  pwm_timebase #(.W(W)) i_pwm_timebase (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_mode(cnt_mode),
    .sync_in(sync_in), .sw_sync(sw_sync), .phase_en(phase_en), .phase_up(phase_up),
    .phase_val(phase_val), .sync_sel(sync_sel), .prd_direct(prd_direct),
    .prd_wr(prd_wr), .prd_wdata(prd_wdata), .count(count), .dir_up(dir_up),
    .zero_evt(zero_evt), .prd_evt(prd_evt), .sync_out(sync_out));

  typedef struct {
    logic [W-1:0] c;
    logic d, z, p, s;
    string tag;
  } exp_t;

  exp_t q[$];
  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic nx();
    @(negedge clk);
    sync_in = 1'b0; sw_sync = 1'b0; prd_wr = 1'b0;
  endtask

  task automatic push(input int c, input logic d, z, p, s, input string tag);
    exp_t e;
    e.c = W'(c); e.d = d; e.z = z; e.p = p; e.s = s; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_vec++;
        if (count !== e.c || dir_up !== e.d || zero_evt !== e.z ||
            prd_evt !== e.p || sync_out !== e.s) begin
          n_bad++;
          $display("FAIL %s: got cnt=%0d dir=%b z=%b p=%b so=%b, expected cnt=%0d dir=%b z=%b p=%b so=%b",
                   e.tag, count, dir_up, zero_evt, prd_evt, sync_out,
                   e.c, e.d, e.z, e.p, e.s);
        end
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang, expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, no strobes while tick_en low
    nx(); push(0, 1, 0, 0, 0, "R1 reset");
    // R12 direct write of period 4
    nx(); prd_direct = 1; prd_wr = 1; prd_wdata = 4; push(0, 1, 0, 0, 0, "R12 direct wr");
    // R2 up mode, R10 strobes, R11 sel 01
    nx(); tick_en = 1; cnt_mode = 2'b00; sync_sel = 2'b01;
    for (int i = 0; i < 10; i++) begin
      int c;
      c = i % 5;
      push(c, 1, c == 0, c == 4, c == 0, "R2 R10 R11 up");
      if (i < 9) nx();
    end
    // R6 hold
    nx(); tick_en = 0; push(0, 1, 0, 0, 0, "R6 hold");
    nx(); push(0, 1, 0, 0, 0, "R6 hold");
    // R3 down mode, sel 10
    nx(); tick_en = 1; cnt_mode = 2'b01; sync_sel = 2'b10;
    for (int i = 0; i < 10; i++) begin
      int c;
      c = (5 - i % 5) % 5;
      push(c, i == 0, c == 0, c == 4, c == 4, "R3 R11 down");
      if (i < 9) nx();
    end
    // R4 up-down, sel 00 without sync
    nx(); cnt_mode = 2'b10; sync_sel = 2'b00;
    for (int i = 0; i < 16; i++) begin
      int t, c;
      t = i % 8;
      c = (t <= 4) ? t : 8 - t;
      push(c, (t >= 1 && t <= 4), c == 0, c == 4, 0, "R4 updown");
      if (i < 15) nx();
    end
    // R5 frozen, shadow write of 6 meanwhile
    nx(); cnt_mode = 2'b11; push(0, 0, 0, 0, 0, "R5 frozen");
    nx(); prd_direct = 0; prd_wr = 1; prd_wdata = 6; push(0, 0, 0, 0, 0, "R5 frozen");
    nx(); push(0, 0, 0, 0, 0, "R5 frozen");
    // R12 shadow transfer at zero: period becomes 6
    nx(); cnt_mode = 2'b00; sync_sel = 2'b01;
    for (int i = 0; i < 7; i++) begin
      push(i, i != 0, i == 0, i == 6, i == 0, "R12 shadow");
      if (i < 6) nx();
    end
    // R8 sync ignored without phase_en; R11 pass-through
    nx(); sync_sel = 2'b00; sync_in = 1; push(0, 1, 1, 0, 1, "R8 R11 ignored");
    // R7 phase load with tick_en low, direction down
    nx(); tick_en = 0; cnt_mode = 2'b10; phase_en = 1; phase_val = 3; phase_up = 0; sync_in = 1;
    push(1, 1, 0, 0, 1, "R7 load");
    nx(); tick_en = 1; phase_en = 0; push(3, 0, 0, 0, 0, "R7 after load");
    nx(); push(2, 0, 0, 0, 0, "R7 down");
    nx(); push(1, 0, 0, 0, 0, "R7 down");
    nx(); push(0, 0, 1, 0, 0, "R7 turn");
    nx(); push(1, 1, 0, 0, 0, "R7 up");
    // R7 load beats wrap
    nx(); cnt_mode = 2'b00;
    for (int c = 2; c < 6; c++) begin
      push(c, 1, 0, 0, 0, "R7 up run");
      nx();
    end
    phase_en = 1; phase_val = 2; phase_up = 1; sync_in = 1;
    push(6, 1, 0, 1, 1, "R7 load at wrap");
    nx(); phase_en = 0; push(2, 1, 0, 0, 0, "R7 priority");
    nx(); push(3, 1, 0, 0, 0, "R7 priority");
    // R9 software sync
    nx(); cnt_mode = 2'b10; phase_en = 1; phase_val = 5; phase_up = 0; sw_sync = 1;
    push(4, 1, 0, 0, 1, "R9 sw sync");
    nx(); phase_en = 0; push(5, 0, 0, 0, 0, "R9 loaded");
    nx(); push(4, 0, 0, 0, 0, "R9 down");
    // R11 code 11
    nx(); cnt_mode = 2'b11; sync_sel = 2'b11; sync_in = 1; push(3, 0, 0, 0, 0, "R11 off R8");
    // R12 direct write of 3
    nx(); prd_direct = 1; prd_wr = 1; prd_wdata = 3; push(3, 0, 0, 0, 0, "R12 direct");
    nx(); cnt_mode = 2'b00; push(3, 0, 0, 1, 0, "R12 direct active");
    nx(); push(0, 1, 1, 0, 0, "R12 R2 wrap");
    nx(); tick_en = 0;
    nx();
    done = 1'b1;
    finish_run();
  end
endmodule